// File: doc/BRIEF.md
# Periodic Saturating Error Count Snapshot

This block is the performance-monitoring back end of a T1 receive framer. It keeps three running tallies of error events: line coding faults (bipolar violations or excessive zeros), frame integrity faults (CRC6 word errors or framing bit errors), and multiframes spent out of receive synchronization. The error detectors that feed it and the host bus are outside the block. Each detector raises a one-cycle strobe for each event it sees.

Time is measured in received frames, with one `frame_tick` per 125 us frame. A select input picks the update interval. The long interval is one second (8000 frames). The short interval is 42 ms (336 frames, fourteen 24-frame superframes). At every interval boundary the three running tallies are copied into held registers that the host can read, and the tallies restart. The held values therefore always describe the last complete interval, and the host has one full interval to read them before they are replaced. A tally that reaches the top of its range stays there for the rest of the interval.

A sticky interval flag is set at every boundary and cleared by a host status read. The flag drives the interrupt output only while the interrupt enable input is high.

Top module: `perf_err_snap`

## Requirements
- R1: With `short_sel`=0 a boundary occurs on every FRAMES_LONG-th `frame_tick`; with `short_sel`=1 it occurs on every FRAMES_SHORT-th `frame_tick`; cycles without `frame_tick` never advance the interval.
- R2: At a boundary, each held output takes the number of strobes of its stream seen since the previous boundary (or since reset). Between boundaries the held outputs do not change.
- R3: A strobe that arrives in the boundary cycle is counted in the new interval, not in the value being stored, so no event is lost.
- R4: Each running tally saturates at its all-ones value (2^width-1) and never wraps to zero within an interval.
- R5: `tmr_status` becomes 1 in the cycle after a boundary and stays 1 until a cycle with `status_rd`=1 and no boundary, after which it is 0. When a read and a boundary fall in the same cycle, the flag stays set.
- R6: `irq` is 1 exactly when `tmr_status` is 1 and `irq_en` is 1; `irq_en`=0 masks it.
- R7: After synchronous reset all held outputs, `tmr_status` and `irq` are 0, and both the tallies and the frame position restart from zero.
- R8: If `short_sel` changes to 1 while the frame position has already passed FRAMES_SHORT-1 frames, the boundary occurs on the next `frame_tick`.
- R9: Strobes are counted in any cycle, whether or not `frame_tick` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse per received frame |
| lcv_evt | input | 1 | Line code violation or excessive-zeros strobe |
| crc_evt | input | 1 | CRC6 or framing bit error strobe |
| oos_evt | input | 1 | Out-of-sync multiframe strobe |
| short_sel | input | 1 | Interval select: 0 = long, 1 = short |
| irq_en | input | 1 | Interrupt enable: 0 = masked, 1 = enabled |
| status_rd | input | 1 | Host read of the interval flag; clears it |
| lcv_held | output | LCV_W | Line code count from the last interval |
| crc_held | output | CRC_W | CRC/framing count from the last interval |
| oos_held | output | OOS_W | Out-of-sync count from the last interval |
| tmr_status | output | 1 | Sticky interval flag |
| irq | output | 1 | Interval interrupt |

## Verification
The first pattern is a quiet stream with a tick in every cycle, which shows whether the boundary falls on exactly the right tick for each interval length. The second is a dense flood of strobes against a slow tick, which pushes every tally past its maximum and tells saturation apart from wraparound. Directed cycles put strobes and status reads on the boundary cycle itself, which separates the rule that carries an event into the new interval from the rule that a boundary wins over a read. A select change in the middle of an interval and a toggling enable are then mixed with long stretches of random strobes, ticks and reads. All of these are compared against a model kept in the bench.

// File: rtl/perf_snap_pkg.sv
package perf_snap_pkg;

    // one strobe per monitored error stream
    typedef struct packed {
        logic lcv;
        logic crc;
        logic oos;
    } err_evt_t;

    // interval length selector
    typedef enum logic {
        IVL_LONG  = 1'b0,
        IVL_SHORT = 1'b1
    } ivl_sel_e;

    // bits needed to hold values 0 .. n
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/perf_ivl_timer.sv
module perf_ivl_timer
    import perf_snap_pkg::*;
#(
    parameter int unsigned FRAMES_LONG  = 8000,
    parameter int unsigned FRAMES_SHORT = 336
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     frame_tick,
    input  ivl_sel_e ivl_sel,
    output logic     boundary
);
    localparam int unsigned POS_W = span_bits(FRAMES_LONG);
    localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(FRAMES_LONG - 1);
    localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(FRAMES_SHORT - 1);

    logic [POS_W-1:0] frame_pos;
    logic [POS_W-1:0] last_pos;

    always_comb begin
        last_pos = (ivl_sel == IVL_SHORT) ? LAST_SHORT : LAST_LONG;
        // ">=" so that a switch to the short interval past its end
        // closes the interval on the next tick
        boundary = frame_tick && (frame_pos >= last_pos);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_pos <= '0;
        end else if (frame_tick) begin
            frame_pos <= boundary ? '0 : frame_pos + 1'b1;
        end
    end

endmodule

// File: rtl/perf_sat_accum.sv
module perf_sat_accum #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         evt,
    input  logic         snap,
    output logic [W-1:0] held
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] run;
    logic         at_top;

    always_comb at_top = (run == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= '0;
            held <= '0;
        end else if (snap) begin
            held <= run;
            run  <= {{(W-1){1'b0}}, evt};
        end else if (evt && !at_top) begin
            run <= run + 1'b1;
        end
    end

endmodule

// File: rtl/perf_ivl_flag.sv
module perf_ivl_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    always_comb irq_o = flag_o & en_i;

endmodule

// File: rtl/perf_err_snap.sv
module perf_err_snap
    import perf_snap_pkg::*;
#(
    parameter int unsigned FRAMES_LONG  = 8000,
    parameter int unsigned FRAMES_SHORT = 336,
    parameter int unsigned LCV_W        = 16,
    parameter int unsigned CRC_W        = 10,
    parameter int unsigned OOS_W        = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             lcv_evt,
    input  logic             crc_evt,
    input  logic             oos_evt,
    input  logic             short_sel,
    input  logic             irq_en,
    input  logic             status_rd,
    output logic [LCV_W-1:0] lcv_held,
    output logic [CRC_W-1:0] crc_held,
    output logic [OOS_W-1:0] oos_held,
    output logic             tmr_status,
    output logic             irq
);
    err_evt_t evt;
    ivl_sel_e ivl_sel;
    logic     boundary;

    always_comb begin
        evt.lcv = lcv_evt;
        evt.crc = crc_evt;
        evt.oos = oos_evt;
        ivl_sel = short_sel ? IVL_SHORT : IVL_LONG;
    end

    perf_ivl_timer #(
        .FRAMES_LONG (FRAMES_LONG),
        .FRAMES_SHORT(FRAMES_SHORT)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .ivl_sel   (ivl_sel),
        .boundary  (boundary)
    );

    perf_sat_accum #(.W(LCV_W)) u_lcv (
        .clk(clk), .rst(rst), .evt(evt.lcv), .snap(boundary), .held(lcv_held)
    );

    perf_sat_accum #(.W(CRC_W)) u_crc (
        .clk(clk), .rst(rst), .evt(evt.crc), .snap(boundary), .held(crc_held)
    );

    perf_sat_accum #(.W(OOS_W)) u_oos (
        .clk(clk), .rst(rst), .evt(evt.oos), .snap(boundary), .held(oos_held)
    );

    perf_ivl_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (boundary),
        .clr_i (status_rd),
        .en_i  (irq_en),
        .flag_o(tmr_status),
        .irq_o (irq)
    );

endmodule

// File: rtl/perf_err_snap_chk.sv
module perf_err_snap_chk #(
    parameter int unsigned FRAMES_LONG = 8000,
    parameter int unsigned LCV_W       = 16,
    parameter int unsigned CRC_W       = 10,
    parameter int unsigned OOS_W       = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_tick,
    input logic             status_rd,
    input logic             irq_en,
    input logic             boundary,
    input logic [LCV_W-1:0] lcv_held,
    input logic [CRC_W-1:0] crc_held,
    input logic [OOS_W-1:0] oos_held,
    input logic             tmr_status,
    input logic             irq
);
    // ticks seen since the last boundary, counted independently
    logic [31:0] ticks_since;

    always_ff @(posedge clk) begin
        if (rst) begin
            ticks_since <= '0;
        end else if (boundary) begin
            ticks_since <= '0;
        end else if (frame_tick) begin
            ticks_since <= ticks_since + 1;
        end
    end

    // R1: no interval lasts longer than the long setting
    a_r1_interval_bound: assert property (@(posedge clk) disable iff (rst)
        ticks_since < FRAMES_LONG);

    // R1: a boundary only ever happens on a frame tick
    a_r1_boundary_on_tick: assert property (@(posedge clk) disable iff (rst)
        boundary |-> frame_tick);

    // R2: held values are frozen between boundaries
    a_r2_held_stable: assert property (@(posedge clk) disable iff (rst)
        !boundary |=> ($stable(lcv_held) && $stable(crc_held) && $stable(oos_held)));

    // R5: a boundary sets the flag
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        boundary |=> tmr_status);

    // R5: a read without a boundary clears the flag
    a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !boundary) |=> !tmr_status);

    // R5: the flag does not rise without a boundary
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !tmr_status) |=> !tmr_status);

    // R6: masked interrupt never asserts
    a_r6_masked: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    // R6: enabled interrupt follows the flag
    a_r6_enabled: assert property (@(posedge clk) disable iff (rst)
        (irq_en && tmr_status) |-> irq);

endmodule

bind perf_err_snap perf_err_snap_chk #(
    .FRAMES_LONG(FRAMES_LONG),
    .LCV_W      (LCV_W),
    .CRC_W      (CRC_W),
    .OOS_W      (OOS_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_tick(frame_tick),
    .status_rd (status_rd),
    .irq_en    (irq_en),
    .boundary  (boundary),
    .lcv_held  (lcv_held),
    .crc_held  (crc_held),
    .oos_held  (oos_held),
    .tmr_status(tmr_status),
    .irq       (irq)
);

// File: tb/test_perf_err_snap.sv
module test_perf_err_snap;
    localparam int CLK_PERIOD = 10;
    localparam int FL = 40;
    localparam int FS = 12;
    localparam int LW = 6;
    localparam int CW = 5;
    localparam int OW = 4;

    logic clk = 1'b0;
    logic rst, frame_tick, lcv_evt, crc_evt, oos_evt, short_sel, irq_en, status_rd;
    logic [LW-1:0] lcv_held;
    logic [CW-1:0] crc_held;
    logic [OW-1:0] oos_held;
    logic tmr_status, irq;

    perf_err_snap #(
        .FRAMES_LONG(FL), .FRAMES_SHORT(FS),
        .LCV_W(LW), .CRC_W(CW), .OOS_W(OW)
    ) i_perf_err_snap (
        .clk(clk), .rst(rst), .frame_tick(frame_tick),
        .lcv_evt(lcv_evt), .crc_evt(crc_evt), .oos_evt(oos_evt),
        .short_sel(short_sel), .irq_en(irq_en), .status_rd(status_rd),
        .lcv_held(lcv_held), .crc_held(crc_held), .oos_held(oos_held),
        .tmr_status(tmr_status), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_pos;
    int m_run [3];
    int m_held [3];
    bit m_flag;
    int m_max [3] = '{(1 << LW) - 1, (1 << CW) - 1, (1 << OW) - 1};

    function automatic int last_of(input bit sel);
        return sel ? FS - 1 : FL - 1;
    endfunction

    task automatic model_reset();
        m_pos = 0;
        m_flag = 0;
        for (int k = 0; k < 3; k++) begin
            m_run[k] = 0;
            m_held[k] = 0;
        end
    endtask

    task automatic model_step(input bit t, input bit rd, input bit e0, input bit e1, input bit e2);
        bit bnd;
        bit ev [3];
        ev[0] = e0; ev[1] = e1; ev[2] = e2;
        bnd = t && (m_pos >= last_of(short_sel));
        if (t) m_pos = bnd ? 0 : m_pos + 1;
        for (int k = 0; k < 3; k++) begin
            if (bnd) begin
                m_held[k] = m_run[k];
                m_run[k] = ev[k] ? 1 : 0;
            end else if (ev[k] && m_run[k] < m_max[k]) begin
                m_run[k] = m_run[k] + 1;
            end
        end
        if (bnd) m_flag = 1;
        else if (rd) m_flag = 0;
    endtask

    task automatic check_val(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        check_val(tag, "lcv_held", int'(lcv_held), m_held[0]);
        check_val(tag, "crc_held", int'(crc_held), m_held[1]);
        check_val(tag, "oos_held", int'(oos_held), m_held[2]);
        check_val(tag, "tmr_status", int'(tmr_status), int'(m_flag));
        check_val("R6", "irq", int'(irq), int'(m_flag && irq_en));
    endtask

    // drive at the falling edge, let one rising edge pass, compare at the next falling edge
    task automatic cyc(input string tag, input bit t, input bit rd, input bit e0, input bit e1, input bit e2);
        frame_tick = t; status_rd = rd;
        lcv_evt = e0; crc_evt = e1; oos_evt = e2;
        @(posedge clk);
        model_step(t, rd, e0, e1, e2);
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; frame_tick = 0; lcv_evt = 0; crc_evt = 0; oos_evt = 0;
        short_sel = 0; irq_en = 1; status_rd = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R7: reset state
        compare("R7");

        // R1: quiet long interval with a tick every cycle
        for (int i = 0; i < 2 * FL + 3; i++) cyc("R1", 1, 0, 0, 0, 0);
        cyc("R5", 0, 1, 0, 0, 0);

        // R9: strobes without ticks still count
        for (int i = 0; i < 7; i++) cyc("R9", 0, 0, 1, 1, (i % 2) == 0);
        for (int i = 0; i < FL; i++) cyc("R9", 1, 0, 0, 0, 0);

        // R4: flood against a slow short interval
        short_sel = 1;
        for (int i = 0; i < FS * 10 * 3; i++) cyc("R4", (i % 10) == 9, 0, 1, 1, 1);

        // R3: strobe on the boundary cycle; R5: read on the same cycle
        while (m_pos != FS - 1) cyc("R3", 1, 0, 0, 0, 0);
        cyc("R3", 1, 1, 1, 1, 1);
        for (int i = 0; i < FS; i++) cyc("R3", 1, 0, 0, 0, 0);
        check_val("R3", "lcv carried", int'(lcv_held), 1);

        // R6: mask toggling with the flag set, then a read
        irq_en = 0; cyc("R6", 0, 0, 0, 0, 0);
        irq_en = 1; cyc("R6", 0, 0, 0, 0, 0);
        cyc("R5", 0, 1, 0, 0, 0);

        // R8: switch to short after the short length has passed
        short_sel = 0;
        for (int i = 0; i < FL; i++) cyc("R8", 1, 0, 0, 0, 0);
        for (int i = 0; i < FS + 5; i++) cyc("R8", 1, 0, 1, 0, 0);
        short_sel = 1;
        cyc("R8", 1, 0, 0, 0, 0);
        check_val("R8", "lcv at switch", int'(lcv_held), FS + 5);

        // R2: random traffic
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 200) == 0) short_sel = ~short_sel;
            if (($urandom % 50) == 0) irq_en = ~irq_en;
            cyc("R2", ($urandom % 3) == 0, ($urandom % 40) == 0,
                ($urandom % 2) == 0, ($urandom % 5) == 0, ($urandom % 9) == 0);
        end

        // R7: reset in the middle of activity
        rst = 1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 0;
        compare("R7");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule